// File: doc/BRIEF.md
# Dual Slave-Oscillator Chaotic Bit Demodulator

This receiver core recovers antipodally keyed data from a chaotic baseband stream. Every clock it takes one signed fixed-point sample (17 bits, 8 of them fraction). The sample drives a first slave oscillator unchanged and a second, identical slave oscillator negated. A slave has no nonlinearity of its own. It infers the nonlinear term from its input by subtracting its own weighted state sum, and uses that estimate to advance its four state variables with a forward-Euler step. The slave that receives the polarity the transmitter actually sent falls into lock within a few hundred samples, and its error collapses toward zero. The other slave keeps a large error.

The absolute error of each slave is averaged over a sliding window of 2^WIN_LOG2 samples. A circular buffer feeds a running accumulator: each new error is added and the error leaving the window is subtracted. Until the buffer has filled once after reset, the leaving error counts as zero. On an external symbol strobe, the two window means are compared and the data bit is registered. Carrier removal, filtering, gain control and symbol timing are done elsewhere.

Top module: `csk_dual_demod`

## Requirements
- R1: While reset is high and in the cycle after it falls, both means read 0 and the data bit reads 0. Reset clears the oscillator states, the window fill count and the accumulators.
- R2: The second slave receives the negated sample. The most negative code, -65536, is mapped to +65535 instead of wrapping.
- R3: Each slave forms w = (K1·p1 + K2·p2 + K3·p3 + K4·p4) >>> 8 with coefficients in 8-fraction-bit form, then g' = r − w and e = |w + |g'| − r|. The error is clamped to 0..65535. With all coefficients zero, the direct error is −2r for negative r and 0 otherwise.
- R4: Each slave's state advances by d >>> STEP_SHIFT per clock, with STEP_SHIFT defaulting to 6, and saturates at 17 bits. The increments are d1 = g'−p2, d2 = p1 + p2>>>1, d3 = 10·(g'−p4) and d4 = p3 + p3>>>1. From zero state, an input of +256 followed by 0 gives direct errors 0 and 24, and inverted errors 512 and 0, under the default coefficients (−673, −155, 150, 199).
- R5: Each mean equals the sum of the last 2^WIN_LOG2 errors shifted right by WIN_LOG2. A sample applied before clock edge E is first counted in the mean after edge E+2.
- R6: Until 2^WIN_LOG2 errors have been written since reset, the error leaving the window counts as zero, whatever data the buffer still holds from before reset.
- R7: An error leaves the mean exactly 2^WIN_LOG2 clocks after it entered it.
- R8: At a clock edge where the strobe is high, the bit becomes 0 if the direct-channel mean is smaller than the inverted-channel mean, and 1 otherwise (ties give 1). Without a strobe the bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | 17 | Signed baseband chaotic sample, 8 fraction bits |
| strobe_i | input | 1 | Symbol strobe; the bit is decided on edges where it is high |
| bit_o | output | 1 | Registered data bit decision |
| mean_dir_o | output | 17 | Window mean error of the direct-input slave |
| mean_inv_o | output | 17 | Window mean error of the negated-input slave |

## Verification
A sample reaches a mean three registers later: the slave error register, the window input stage, and the accumulator. The bench therefore reads a mean on the falling edge after the third rising edge following the sample, and also confirms that the mean has not moved one edge earlier. A departing error is checked on the falling edges just before and just after the rising edge 2^WIN_LOG2 clocks after entry. The bit is read on the falling edge right after the strobed rising edge, and is checked again before the next strobe to confirm it held.

// File: rtl/csk_demod_pkg.sv
package csk_demod_pkg;
  // Number of slave channels: one fed direct, one fed negated
  localparam int CSK_NUM_CH = 2;

  typedef enum int {
    CH_DIRECT   = 0,
    CH_INVERTED = 1
  } csk_chan_e;

  // Default output weights, signed with 8 fraction bits
  localparam int CSK_K1 = -673;
  localparam int CSK_K2 = -155;
  localparam int CSK_K3 = 150;
  localparam int CSK_K4 = 199;
endpackage

// File: rtl/csk_slave_osc.sv
module csk_slave_osc #(
  parameter int DATA_W     = 17,
  parameter int COEF_W     = 12,
  parameter int COEF_FRAC  = 8,
  parameter int STEP_SHIFT = 6,
  parameter int K1         = -673,
  parameter int K2         = -155,
  parameter int K3         = 150,
  parameter int K4         = 199
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0]        err_o
);
  localparam int NST = 4;
  localparam int PW  = DATA_W + COEF_W;
  localparam int SW  = PW + 2;
  localparam int WW  = DATA_W + COEF_W - COEF_FRAC + 3;
  localparam logic signed [WW-1:0] MAXW = WW'((1 << (DATA_W-1)) - 1);
  localparam logic signed [WW-1:0] MINW = -MAXW - WW'(1);

  function automatic logic signed [DATA_W-1:0] sat_d(input logic signed [WW-1:0] v);
    logic signed [WW-1:0] c;
    c = (v > MAXW) ? MAXW : ((v < MINW) ? MINW : v);
    return DATA_W'(c);
  endfunction

  logic signed [DATA_W-1:0] p_q   [NST];
  logic signed [DATA_W-1:0] p_nx  [NST];
  logic signed [PW-1:0]     prod  [NST];
  logic signed [WW-1:0]     pw    [NST];
  logic signed [WW-1:0]     dlt   [NST];

  // Weighted state products
  generate
    for (genvar gi = 0; gi < NST; gi++) begin : g_mul
      logic signed [COEF_W-1:0] kc;
      assign kc = (gi == 0) ? COEF_W'(K1) :
                  (gi == 1) ? COEF_W'(K2) :
                  (gi == 2) ? COEF_W'(K3) : COEF_W'(K4);
      assign prod[gi] = PW'(p_q[gi]) * PW'(kc);
      assign pw[gi]   = WW'(p_q[gi]);
    end
  endgenerate

  logic signed [SW-1:0] wsum;
  logic signed [WW-1:0] w_s, r_s, gp, gabs, y_s, e_s, eabs, e_sat, g_s, x4;

  always_comb begin
    wsum  = SW'(prod[0]) + SW'(prod[1]) + SW'(prod[2]) + SW'(prod[3]);
    w_s   = WW'(wsum >>> COEF_FRAC);
    r_s   = WW'(sample_i);
    gp    = r_s - w_s;                         // recovered nonlinearity
    gabs  = (gp < 0) ? -gp : gp;
    y_s   = w_s + gabs;                        // slave output
    e_s   = y_s - r_s;                         // synchronisation error
    eabs  = (e_s < 0) ? -e_s : e_s;
    e_sat = (eabs > MAXW) ? MAXW : eabs;
    g_s   = WW'(sat_d(gp));
    x4    = g_s - pw[3];
    dlt[0] = g_s - pw[1];
    dlt[1] = pw[0] + (pw[1] >>> 1);
    dlt[2] = (x4 <<< 3) + (x4 <<< 1);
    dlt[3] = pw[2] + (pw[2] >>> 1);
  end

  // Forward-Euler state update
  generate
    for (genvar gs = 0; gs < NST; gs++) begin : g_step
      assign p_nx[gs] = sat_d(pw[gs] + (dlt[gs] >>> STEP_SHIFT));
      always_ff @(posedge clk_i) begin
        if (rst_i) p_q[gs] <= '0;
        else       p_q[gs] <= p_nx[gs];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) err_o <= '0;
    else       err_o <= DATA_W'(e_sat);
  end
endmodule

// File: rtl/csk_err_window.sv
module csk_err_window #(
  parameter int DATA_W   = 17,
  parameter int WIN_LOG2 = 11
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] err_i,
  output logic [DATA_W-1:0] mean_o
);
  localparam int DEPTH = 1 << WIN_LOG2;
  localparam int ACC_W = DATA_W + WIN_LOG2;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [WIN_LOG2-1:0] ptr_q;
  logic [WIN_LOG2:0]   fill_q;
  logic [DATA_W-1:0]   old_q, new_q;
  logic                full_q;
  logic [ACC_W-1:0]    acc_q;

  // Circular buffer, read-before-write, no reset (block RAM friendly)
  always_ff @(posedge clk_i) begin
    old_q      <= mem[ptr_q];
    mem[ptr_q] <= err_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_q  <= '0;
      fill_q <= '0;
      new_q  <= '0;
      full_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      ptr_q  <= ptr_q + 1'b1;
      if (fill_q != (WIN_LOG2+1)'(DEPTH)) fill_q <= fill_q + 1'b1;
      full_q <= (fill_q == (WIN_LOG2+1)'(DEPTH));
      new_q  <= err_i;
      acc_q  <= acc_q + ACC_W'(new_q) - (full_q ? ACC_W'(old_q) : '0);
    end
  end

  assign mean_o = DATA_W'(acc_q >> WIN_LOG2);

  AST_ERR_NONNEG: assert property (@(posedge clk_i) disable iff (rst_i)
    err_i[DATA_W-1] == 1'b0); // R3
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    fill_q <= (WIN_LOG2+1)'(DEPTH)); // R6
  AST_ACC_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> acc_q == '0); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_q[ACC_W-1] == 1'b0); // R5
endmodule

// File: rtl/csk_bit_decide.sv
module csk_bit_decide #(
  parameter int DATA_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] mean_dir_i,
  input  logic [DATA_W-1:0] mean_inv_i,
  output logic              bit_o
);
  logic signed [DATA_W:0] diff;
  assign diff = $signed({1'b0, mean_dir_i}) - $signed({1'b0, mean_inv_i});

  always_ff @(posedge clk_i) begin
    if (rst_i)         bit_o <= 1'b0;
    else if (strobe_i) bit_o <= !(diff < 0);
  end

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !strobe_i |=> $stable(bit_o)); // R8
  AST_BIT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_i && (mean_dir_i < mean_inv_i)) |=> !bit_o); // R8
endmodule

// File: rtl/csk_dual_demod.sv
module csk_dual_demod #(
  parameter int DATA_W     = 17,
  parameter int COEF_W     = 12,
  parameter int COEF_FRAC  = 8,
  parameter int STEP_SHIFT = 6,
  parameter int WIN_LOG2   = 11,
  parameter int K1         = csk_demod_pkg::CSK_K1,
  parameter int K2         = csk_demod_pkg::CSK_K2,
  parameter int K3         = csk_demod_pkg::CSK_K3,
  parameter int K4         = csk_demod_pkg::CSK_K4
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     strobe_i,
  output logic                     bit_o,
  output logic [DATA_W-1:0]        mean_dir_o,
  output logic [DATA_W-1:0]        mean_inv_o
);
  localparam int NCH = csk_demod_pkg::CSK_NUM_CH;
  localparam logic signed [DATA_W-1:0] MAXS = DATA_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [DATA_W-1:0] MINS = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] neg_s;
  logic signed [DATA_W-1:0] ch_in   [NCH];
  logic [DATA_W-1:0]        ch_err  [NCH];
  logic [DATA_W-1:0]        ch_mean [NCH];

  // Saturating negation for the second slave
  assign neg_s = (sample_i == MINS) ? MAXS : -sample_i;

  generate
    for (genvar gc = 0; gc < NCH; gc++) begin : g_chan
      assign ch_in[gc] = (gc == int'(csk_demod_pkg::CH_INVERTED)) ? neg_s : sample_i;

      csk_slave_osc #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
        .STEP_SHIFT(STEP_SHIFT), .K1(K1), .K2(K2), .K3(K3), .K4(K4)
      ) u_slave (
        .clk_i(clk_i), .rst_i(rst_i), .sample_i(ch_in[gc]), .err_o(ch_err[gc])
      );

      csk_err_window #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_win (
        .clk_i(clk_i), .rst_i(rst_i), .err_i(ch_err[gc]), .mean_o(ch_mean[gc])
      );
    end
  endgenerate

  assign mean_dir_o = ch_mean[int'(csk_demod_pkg::CH_DIRECT)];
  assign mean_inv_o = ch_mean[int'(csk_demod_pkg::CH_INVERTED)];

  csk_bit_decide #(.DATA_W(DATA_W)) u_decide (
    .clk_i(clk_i), .rst_i(rst_i), .strobe_i(strobe_i),
    .mean_dir_i(mean_dir_o), .mean_inv_i(mean_inv_o), .bit_o(bit_o)
  );
endmodule

// File: tb/csk_dual_demod_tb_top.sv
module csk_dual_demod_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic signed [16:0] sample = '0;
  logic signed [16:0] w_sample = '0;
  logic bit_i, bit_w;
  logic [16:0] md_i, mi_i, md_w, mi_w;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  // Zero weights: errors depend on the sample only; window of 16
  csk_dual_demod #(.WIN_LOG2(4), .K1(0), .K2(0), .K3(0), .K4(0)) dut_i (
    .clk_i(clk), .rst_i(rst), .sample_i(sample), .strobe_i(strobe),
    .bit_o(bit_i), .mean_dir_o(md_i), .mean_inv_o(mi_i));

  // Default weights, window of 4: oscillator feedback check
  csk_dual_demod #(.WIN_LOG2(2)) dut_w (
    .clk_i(clk), .rst_i(rst), .sample_i(w_sample), .strobe_i(1'b0),
    .bit_o(bit_w), .mean_dir_o(md_w), .mean_inv_o(mi_w));

  localparam int NV = 5;
  localparam int VEC_R [NV] = '{100, -65536, 0, 65535, -300};
  localparam int VEC_B [NV] = '{0, 1, 1, 0, 1};

  function automatic int clip(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction
  function automatic int exp_dir(input int r);   // R3 with zero weights
    return (r < 0) ? clip(-2 * r) : 0;
  endfunction
  function automatic int exp_inv(input int r);   // R2 then R3
    int n;
    n = (r == -65536) ? 65535 : -r;
    return (n < 0) ? clip(-2 * n) : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    int prev_bit;
    repeat (3) @(negedge clk);
    chk("R1 reset dir mean", int'(md_i), 0);
    chk("R1 reset inv mean", int'(mi_i), 0);
    chk("R1 reset bit", int'(bit_i), 0);
    rst = 1'b0;
    prev_bit = 0;

    for (int v = 0; v < NV; v++) begin
      sample = 17'(VEC_R[v]);
      repeat (20) @(negedge clk);
      chk("R3 R5 direct mean", int'(md_i), exp_dir(VEC_R[v]));
      chk("R2 inverted mean", int'(mi_i), exp_inv(VEC_R[v]));
      chk("R8 bit held without strobe", int'(bit_i), prev_bit);
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk("R8 bit on strobe", int'(bit_i), VEC_B[v]);
      prev_bit = VEC_B[v];
    end

    // Reset after a 1 decision with stale buffer contents
    rst = 1'b1;
    sample = '0;
    repeat (3) @(negedge clk);
    chk("R1 bit cleared by reset", int'(bit_i), 0);
    chk("R1 dir mean cleared", int'(md_i), 0);

    // Single impulse: latency, fill guard and departure
    rst = 1'b0;
    sample = -17'sd8;
    w_sample = 17'sd256;
    @(negedge clk);                  // after E1
    sample = '0;
    w_sample = '0;
    @(negedge clk);                  // after E2
    chk("R5 not yet counted", int'(md_i), 0);
    @(negedge clk);                  // after E3
    chk("R5 impulse counted", int'(md_i), 1);
    chk("R4 first direct error", int'(md_w), 0);
    chk("R4 first inverted error", int'(mi_w), 128);
    @(negedge clk);                  // after E4
    chk("R4 second direct error", int'(md_w), 6);
    chk("R4 second inverted error", int'(mi_w), 128);
    repeat (14) @(negedge clk);      // after E18
    chk("R6 stale data not subtracted", int'(md_i), 1);
    @(negedge clk);                  // after E19
    chk("R7 impulse left window", int'(md_i), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule